// File: doc/BRIEF.md
# MOESI Coherence Directory

This block is the ordering point for one bank of coherent memory shared by a small group of caching agents. Each agent asks for a 64-byte line either to read it or to gain write ownership of it, and later gives up lines it owns through a write-back. For every line it tracks, the directory keeps the coherence state, a bit-vector of clean sharers and the ID of the owning agent. The directory uses this record to decide which agents must take part in a request. It invalidates clean copies, tells an owning agent to hand its data straight to the requester, or lets a single-cycle memory model supply or absorb the line.

The directory handles one transaction at a time. It takes a request and sends invalidate or forward snoops, in a single cycle, only to the agents its record lists. It then waits until every one of those agents has acknowledged. Only after that does it issue a one-cycle grant carrying the final line state for the requester. Memory fill and memory write strobes are raised in the grant cycle. A snoop marked exclusive tells the owning agent to drop the line after forwarding it. A non-exclusive snoop tells the owner to keep the line as the dirty owner. Lines enter a fully associative table when they are first requested and leave it when no agent holds them any more.

Top module: `moesi_directory`

## Requirements
- R1: After reset the directory accepts a request (req_ready_o high), and it drives no grant, no snoop and no memory strobe.
- R2: A read-shared request (kind 0) to a line no agent holds gets a memory fill and a grant in Exclusive (state code 2), with no snoop.
- R3: A read-shared request to a line held only by clean sharers gets a memory fill and a grant in Shared (code 1), with no snoop.
- R4: A read-shared request to a line another agent holds in Exclusive, Owned or Modified sends one non-exclusive forward to that owner only. The grant is Shared with gnt_from_cache_o high, and there is no memory fill or memory write. The owner keeps ownership, and the line becomes Owned.
- R5: A read-for-ownership request (kind 1) invalidates exactly the other listed sharers, sends an exclusive forward to a different owner if there is one, snoops no other agent and never the requester, and grants Modified (code 4).
- R6: Once a request is accepted, no other request is accepted and no grant is issued until every snooped agent has acknowledged. The grant then comes as a single-cycle pulse.
- R7: A write-back (kind 2) from the owner raises mem_wr_o and grants Invalid (code 0). The line stays tracked as Shared if clean sharers remain, and otherwise it is released, so a later read-shared request is served from memory.
- R8: A write-back from an agent that is not the owner writes nothing to memory and removes only that agent from the sharer vector.
- R9: Tracking is per 64-byte line: byte addresses that differ only in bits 5:0 refer to one line and conflict.
- R10: Across every sequence of grants and snoops, at most one agent holds a line in Modified or Exclusive. No agent holds it in Shared while another holds it in Modified or Exclusive.
- R11: A read-for-ownership request from the agent that already owns an Owned line invalidates only the sharers. It forwards nothing and does not fill from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_agent_i | input | ID_W | Requesting agent |
| req_kind_i | input | 2 | 0 read-shared, 1 read-for-ownership, 2 write-back |
| req_addr_i | input | ADDR_W | Byte address of the line |
| req_ready_o | output | 1 | Request taken at this edge when valid |
| snp_inv_o | output | N_AGENTS | One-cycle invalidate per agent |
| snp_fwd_o | output | N_AGENTS | One-cycle forward-to-requester per agent |
| snp_fwd_excl_o | output | 1 | Forwarding owner must drop the line |
| snp_addr_o | output | ADDR_W | Line address of the snoop |
| ack_i | input | N_AGENTS | Snoop acknowledgement per agent |
| gnt_valid_o | output | 1 | Grant pulse |
| gnt_agent_o | output | ID_W | Agent being granted |
| gnt_state_o | output | 3 | Final state: 0 I, 1 S, 2 E, 3 O, 4 M |
| gnt_from_cache_o | output | 1 | Data supplied by another agent |
| mem_rd_o | output | 1 | Memory fill strobe |
| mem_wr_o | output | 1 | Memory write-back strobe |
| mem_addr_o | output | ADDR_W | Line address for memory |

## Verification
The bench plays all four agents across three lines. It steps each line through first fill, forwarded reads from an Exclusive owner and from a Modified owner, an owner upgrading out of Owned, and ownership stolen by another agent. Write-backs from owners and from plain sharers are followed by fresh reads. These tell an Exclusive grant apart from a Shared one, and a cache-supplied grant apart from a memory fill. They also show whether the snoop vectors name exactly the holders. Byte offsets inside a line show that sub-line writers still conflict. Acknowledgements are spread several cycles apart to show that the grant waits for the last one. A per-agent state model checks the single-writer invariant after every grant.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int unsigned LINE_OFS = 6;

  typedef enum logic [2:0] {
    LS_I = 3'd0,
    LS_S = 3'd1,
    LS_E = 3'd2,
    LS_O = 3'd3,
    LS_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    RQ_RD_SHR = 2'd0,
    RQ_RD_OWN = 2'd1,
    RQ_WBACK  = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    EN_IDLE,
    EN_SNOOP,
    EN_WAIT,
    EN_GRANT
  } eng_st_e;
endpackage

// File: rtl/dir_table.sv
module dir_table
  import coh_pkg::*;
#(
  parameter int unsigned ENTRIES  = 8,
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned TAG_W    = 10,
  localparam int unsigned IDX_W   = $clog2(ENTRIES),
  localparam int unsigned ID_W    = $clog2(N_AGENTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TAG_W-1:0]    lk_tag_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    hit_idx_o,
  output logic                free_o,
  output logic [IDX_W-1:0]    free_idx_o,
  output line_st_e            rd_state_o,
  output logic [N_AGENTS-1:0] rd_sharers_o,
  output logic [ID_W-1:0]     rd_owner_o,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [TAG_W-1:0]    wr_tag_i,
  input  line_st_e            wr_state_i,
  input  logic [N_AGENTS-1:0] wr_sharers_i,
  input  logic [ID_W-1:0]     wr_owner_i
);
  logic [ENTRIES-1:0]  vld_w;
  logic [ENTRIES-1:0]  match_w;
  line_st_e            st_w  [ENTRIES];
  logic [N_AGENTS-1:0] sh_w  [ENTRIES];
  logic [ID_W-1:0]     own_w [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic                vld_q;
    logic [TAG_W-1:0]    tag_q;
    line_st_e            st_q;
    logic [N_AGENTS-1:0] sh_q;
    logic [ID_W-1:0]     own_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        tag_q <= '0;
        st_q  <= LS_I;
        sh_q  <= '0;
        own_q <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        vld_q <= (wr_state_i != LS_I);
        tag_q <= wr_tag_i;
        st_q  <= wr_state_i;
        sh_q  <= wr_sharers_i;
        own_q <= wr_owner_i;
      end
    end

    assign vld_w[g]   = vld_q;
    assign match_w[g] = vld_q && (tag_q == lk_tag_i);
    assign st_w[g]    = st_q;
    assign sh_w[g]    = sh_q;
    assign own_w[g]   = own_q;
  end

  always_comb begin
    hit_o      = 1'b0;
    hit_idx_o  = '0;
    free_o     = 1'b0;
    free_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_w[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
      end
      if (!vld_w[i]) begin
        free_o     = 1'b1;
        free_idx_o = IDX_W'(i);
      end
    end
  end

  assign rd_state_o   = hit_o ? st_w[hit_idx_o]  : LS_I;
  assign rd_sharers_o = hit_o ? sh_w[hit_idx_o]  : '0;
  assign rd_owner_o   = hit_o ? own_w[hit_idx_o] : '0;
endmodule

// File: rtl/dir_policy.sv
module dir_policy
  import coh_pkg::*;
#(
  parameter int unsigned N_AGENTS = 4,
  localparam int unsigned ID_W    = $clog2(N_AGENTS)
) (
  input  req_kind_e           kind_i,
  input  logic [ID_W-1:0]     agent_i,
  input  line_st_e            state_i,
  input  logic [N_AGENTS-1:0] sharers_i,
  input  logic [ID_W-1:0]     owner_i,
  output line_st_e            nxt_state_o,
  output logic [N_AGENTS-1:0] nxt_sharers_o,
  output logic [ID_W-1:0]     nxt_owner_o,
  output logic [N_AGENTS-1:0] inv_o,
  output logic [N_AGENTS-1:0] fwd_o,
  output logic                fwd_excl_o,
  output line_st_e            gnt_state_o,
  output logic                from_cache_o,
  output logic                mem_rd_o,
  output logic                mem_wr_o
);
  logic [N_AGENTS-1:0] req_bit;
  logic [N_AGENTS-1:0] own_bit;
  logic                has_own;
  logic                self_own;

  always_comb begin
    req_bit          = '0;
    req_bit[agent_i] = 1'b1;
    has_own          = (state_i == LS_E) || (state_i == LS_O) || (state_i == LS_M);
    own_bit          = '0;
    if (has_own) own_bit[owner_i] = 1'b1;
    self_own         = has_own && (owner_i == agent_i);

    nxt_state_o   = state_i;
    nxt_sharers_o = sharers_i;
    nxt_owner_o   = owner_i;
    inv_o         = '0;
    fwd_o         = '0;
    fwd_excl_o    = 1'b0;
    gnt_state_o   = LS_I;
    from_cache_o  = 1'b0;
    mem_rd_o      = 1'b0;
    mem_wr_o      = 1'b0;

    unique case (kind_i)
      RQ_RD_SHR: begin
        if (!has_own) begin
          mem_rd_o = 1'b1;
          if (state_i == LS_I) begin
            nxt_state_o   = LS_E;
            nxt_sharers_o = '0;
            nxt_owner_o   = agent_i;
            gnt_state_o   = LS_E;
          end else begin
            nxt_state_o   = LS_S;
            nxt_sharers_o = sharers_i | req_bit;
            gnt_state_o   = LS_S;
          end
        end else if (self_own) begin
          gnt_state_o = state_i;
        end else begin
          // owner keeps the dirty copy, reader joins the sharers
          fwd_o         = own_bit;
          from_cache_o  = 1'b1;
          nxt_state_o   = LS_O;
          nxt_sharers_o = sharers_i | req_bit;
          gnt_state_o   = LS_S;
        end
      end
      RQ_RD_OWN: begin
        inv_o         = sharers_i & ~req_bit;
        fwd_o         = self_own ? '0 : own_bit;
        fwd_excl_o    = has_own && !self_own;
        from_cache_o  = has_own && !self_own;
        mem_rd_o      = !has_own && ((sharers_i & req_bit) == '0);
        nxt_state_o   = LS_M;
        nxt_sharers_o = '0;
        nxt_owner_o   = agent_i;
        gnt_state_o   = LS_M;
      end
      RQ_WBACK: begin
        if (self_own) begin
          // E may have been silently dirtied, so it writes back too
          mem_wr_o    = 1'b1;
          nxt_owner_o = '0;
          if (state_i == LS_O && sharers_i != '0) begin
            nxt_state_o = LS_S;
          end else begin
            nxt_state_o   = LS_I;
            nxt_sharers_o = '0;
          end
        end else begin
          nxt_sharers_o = sharers_i & ~req_bit;
          if (state_i == LS_S && (sharers_i & ~req_bit) == '0) nxt_state_o = LS_I;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_engine.sv
module dir_engine
  import coh_pkg::*;
#(
  parameter int unsigned N_AGENTS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [N_AGENTS-1:0] targets_i,
  input  logic [N_AGENTS-1:0] ack_i,
  output logic                idle_o,
  output logic                snoop_o,
  output logic                grant_o
);
  eng_st_e             st_q;
  logic [N_AGENTS-1:0] pend_q;
  logic [N_AGENTS-1:0] pend_left;

  assign pend_left = pend_q & ~ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= EN_IDLE;
      pend_q <= '0;
    end else begin
      unique case (st_q)
        EN_IDLE: if (start_i) begin
          pend_q <= targets_i;
          st_q   <= (targets_i != '0) ? EN_SNOOP : EN_GRANT;
        end
        EN_SNOOP, EN_WAIT: begin
          pend_q <= pend_left;
          st_q   <= (pend_left == '0) ? EN_GRANT : EN_WAIT;
        end
        EN_GRANT: st_q <= EN_IDLE;
        default:  st_q <= EN_IDLE;
      endcase
    end
  end

  assign idle_o  = (st_q == EN_IDLE);
  assign snoop_o = (st_q == EN_SNOOP);
  assign grant_o = (st_q == EN_GRANT);
endmodule

// File: rtl/moesi_directory.sv
module moesi_directory
  import coh_pkg::*;
#(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned ENTRIES  = 8,
  parameter int unsigned ADDR_W   = 16,
  localparam int unsigned ID_W    = $clog2(N_AGENTS),
  localparam int unsigned TAG_W   = ADDR_W - LINE_OFS,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [ID_W-1:0]     req_agent_i,
  input  logic [1:0]          req_kind_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  output logic                req_ready_o,
  output logic [N_AGENTS-1:0] snp_inv_o,
  output logic [N_AGENTS-1:0] snp_fwd_o,
  output logic                snp_fwd_excl_o,
  output logic [ADDR_W-1:0]   snp_addr_o,
  input  logic [N_AGENTS-1:0] ack_i,
  output logic                gnt_valid_o,
  output logic [ID_W-1:0]     gnt_agent_o,
  output logic [2:0]          gnt_state_o,
  output logic                gnt_from_cache_o,
  output logic                mem_rd_o,
  output logic                mem_wr_o,
  output logic [ADDR_W-1:0]   mem_addr_o
);
  logic [TAG_W-1:0]    lk_tag;
  logic [LINE_OFS-1:0] unused_ofs;
  logic                hit, free;
  logic [IDX_W-1:0]    hit_idx, free_idx;
  line_st_e            cur_st;
  logic [N_AGENTS-1:0] cur_sh;
  logic [ID_W-1:0]     cur_own;

  line_st_e            p_st, p_gnt;
  logic [N_AGENTS-1:0] p_sh, p_inv, p_fwd;
  logic [ID_W-1:0]     p_own;
  logic                p_excl, p_cache, p_rd, p_wr;

  logic                idle, snoop, grant, accept;

  line_st_e            st_q, gnt_q;
  logic [N_AGENTS-1:0] sh_q, inv_q, fwd_q;
  logic [ID_W-1:0]     own_q, agent_q;
  logic [TAG_W-1:0]    tag_q;
  logic [IDX_W-1:0]    idx_q;
  logic                excl_q, cache_q, rd_q, wr_q;

  assign lk_tag     = req_addr_i[ADDR_W-1:LINE_OFS];
  assign unused_ofs = req_addr_i[LINE_OFS-1:0];

  dir_table #(
    .ENTRIES (ENTRIES),
    .N_AGENTS(N_AGENTS),
    .TAG_W   (TAG_W)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_tag_i    (lk_tag),
    .hit_o       (hit),
    .hit_idx_o   (hit_idx),
    .free_o      (free),
    .free_idx_o  (free_idx),
    .rd_state_o  (cur_st),
    .rd_sharers_o(cur_sh),
    .rd_owner_o  (cur_own),
    .wr_en_i     (grant),
    .wr_idx_i    (idx_q),
    .wr_tag_i    (tag_q),
    .wr_state_i  (st_q),
    .wr_sharers_i(sh_q),
    .wr_owner_i  (own_q)
  );

  dir_policy #(
    .N_AGENTS(N_AGENTS)
  ) u_policy (
    .kind_i       (req_kind_e'(req_kind_i)),
    .agent_i      (req_agent_i),
    .state_i      (cur_st),
    .sharers_i    (cur_sh),
    .owner_i      (cur_own),
    .nxt_state_o  (p_st),
    .nxt_sharers_o(p_sh),
    .nxt_owner_o  (p_own),
    .inv_o        (p_inv),
    .fwd_o        (p_fwd),
    .fwd_excl_o   (p_excl),
    .gnt_state_o  (p_gnt),
    .from_cache_o (p_cache),
    .mem_rd_o     (p_rd),
    .mem_wr_o     (p_wr)
  );

  assign req_ready_o = idle && (hit || free);
  assign accept      = req_valid_i && req_ready_o;

  dir_engine #(
    .N_AGENTS(N_AGENTS)
  ) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .targets_i(p_inv | p_fwd),
    .ack_i    (ack_i),
    .idle_o   (idle),
    .snoop_o  (snoop),
    .grant_o  (grant)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= LS_I;
      gnt_q   <= LS_I;
      sh_q    <= '0;
      inv_q   <= '0;
      fwd_q   <= '0;
      own_q   <= '0;
      agent_q <= '0;
      tag_q   <= '0;
      idx_q   <= '0;
      excl_q  <= 1'b0;
      cache_q <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      st_q    <= p_st;
      gnt_q   <= p_gnt;
      sh_q    <= p_sh;
      inv_q   <= p_inv;
      fwd_q   <= p_fwd;
      own_q   <= p_own;
      agent_q <= req_agent_i;
      tag_q   <= lk_tag;
      idx_q   <= hit ? hit_idx : free_idx;
      excl_q  <= p_excl;
      cache_q <= p_cache;
      rd_q    <= p_rd;
      wr_q    <= p_wr;
    end
  end

  assign snp_inv_o        = snoop ? inv_q : '0;
  assign snp_fwd_o        = snoop ? fwd_q : '0;
  assign snp_fwd_excl_o   = snoop && excl_q;
  assign snp_addr_o       = {tag_q, {LINE_OFS{1'b0}}};
  assign gnt_valid_o      = grant;
  assign gnt_agent_o      = agent_q;
  assign gnt_state_o      = gnt_q;
  assign gnt_from_cache_o = grant && cache_q;
  assign mem_rd_o         = grant && rd_q;
  assign mem_wr_o         = grant && wr_q;
  assign mem_addr_o       = {tag_q, {LINE_OFS{1'b0}}};
endmodule

// File: rtl/dir_checks.sv
module dir_checks #(
  parameter int unsigned N_AGENTS = 4,
  localparam int unsigned ID_W    = $clog2(N_AGENTS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic [ID_W-1:0]     req_agent_i,
  input logic                req_ready_o,
  input logic [N_AGENTS-1:0] snp_inv_o,
  input logic [N_AGENTS-1:0] snp_fwd_o,
  input logic [N_AGENTS-1:0] ack_i,
  input logic                gnt_valid_o,
  input logic [2:0]          gnt_state_o,
  input logic                gnt_from_cache_o,
  input logic                mem_rd_o,
  input logic                mem_wr_o
);
  logic [N_AGENTS-1:0] outst_q;
  logic [ID_W-1:0]     req_q;
  logic                any_snp;

  assign any_snp = (snp_inv_o != '0) || (snp_fwd_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q <= '0;
      req_q   <= '0;
    end else begin
      if (any_snp) outst_q <= (snp_inv_o | snp_fwd_o) & ~ack_i;
      else         outst_q <= outst_q & ~ack_i;
      if (req_valid_i && req_ready_o) req_q <= req_agent_i;
    end
  end

  assert_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_snp || gnt_valid_o) |-> !req_ready_o)
    else $error("request accepted while a transaction is open");

  assert_acks_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> (outst_q == '0))
    else $error("grant before all acknowledgements");

  assert_grant_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |=> !gnt_valid_o)
    else $error("grant longer than one cycle");

  assert_single_fwd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(snp_fwd_o) && ((snp_inv_o & snp_fwd_o) == '0))
    else $error("forward to several agents or overlapping snoops");

  assert_no_self_snoop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_snp |-> (!snp_inv_o[req_q] && !snp_fwd_o[req_q]))
    else $error("requester snooped");

  assert_snoop_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_snp |=> !any_snp)
    else $error("snoop held more than one cycle");

  assert_cache_no_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_from_cache_o |-> !mem_rd_o)
    else $error("memory fill on a cache-supplied grant");

  assert_wb_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (gnt_valid_o && gnt_state_o == 3'd0 && !mem_rd_o))
    else $error("memory write outside a write-back grant");
endmodule

bind moesi_directory dir_checks #(
  .N_AGENTS(N_AGENTS)
) u_dir_checks (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_agent_i     (req_agent_i),
  .req_ready_o     (req_ready_o),
  .snp_inv_o       (snp_inv_o),
  .snp_fwd_o       (snp_fwd_o),
  .ack_i           (ack_i),
  .gnt_valid_o     (gnt_valid_o),
  .gnt_state_o     (gnt_state_o),
  .gnt_from_cache_o(gnt_from_cache_o),
  .mem_rd_o        (mem_rd_o),
  .mem_wr_o        (mem_wr_o)
);

// File: tb/moesi_directory_test.sv
`timescale 1ns/1ps
module moesi_directory_test;
  localparam int KRS = 0, KRO = 1, KWB = 2;
  localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_agent_i = '0;
  logic [1:0]  req_kind_i = '0;
  logic [15:0] req_addr_i = '0;
  logic        req_ready_o;
  logic [3:0]  snp_inv_o, snp_fwd_o;
  logic        snp_fwd_excl_o;
  logic [15:0] snp_addr_o;
  logic [3:0]  ack_i = '0;
  logic        gnt_valid_o;
  logic [1:0]  gnt_agent_o;
  logic [2:0]  gnt_state_o;
  logic        gnt_from_cache_o, mem_rd_o, mem_wr_o;
  logic [15:0] mem_addr_o;

  int n_chk = 0;
  int n_err = 0;
  int mdl [3][4];

  always #5 clk_i = ~clk_i;

  moesi_directory uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_agent_i(req_agent_i),
    .req_kind_i(req_kind_i), .req_addr_i(req_addr_i), .req_ready_o(req_ready_o),
    .snp_inv_o(snp_inv_o), .snp_fwd_o(snp_fwd_o), .snp_fwd_excl_o(snp_fwd_excl_o),
    .snp_addr_o(snp_addr_o), .ack_i(ack_i),
    .gnt_valid_o(gnt_valid_o), .gnt_agent_o(gnt_agent_o), .gnt_state_o(gnt_state_o),
    .gnt_from_cache_o(gnt_from_cache_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_addr_o(mem_addr_o)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int lid(input logic [15:0] a);
    if (a[15:6] == 10'h040) return 0;
    if (a[15:6] == 10'h041) return 1;
    return 2;
  endfunction

  // R10: single-writer invariant over the bench's per-agent model
  task automatic check_invariant(input int ln);
    int n_wr = 0;
    int n_sh = 0;
    for (int a = 0; a < 4; a++) begin
      if (mdl[ln][a] == SM || mdl[ln][a] == SE) n_wr++;
      if (mdl[ln][a] == SS) n_sh++;
    end
    check(n_wr <= 1, "R10", "writers on line", n_wr, 1);
    check(!(n_wr == 1 && n_sh > 0), "R10", "sharers beside writer", n_sh, 0);
  endtask

  task automatic transact(input int ag, input int kind, input logic [15:0] addr,
                          input logic [3:0] e_inv, input logic [3:0] e_fwd,
                          input bit e_excl, input int e_st, input bit e_cache,
                          input bit e_rd, input bit e_wr, input int gap,
                          input string rq);
    logic [3:0] pend = '0;
    logic [3:0] s_inv = '0;
    logic [3:0] s_fwd = '0;
    bit s_excl = 0;
    bit snooped = 0;
    bit got = 0;
    bit busy_bad = 0;
    int gcnt = 0;
    int ln = lid(addr);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_agent_i = 2'(ag);
    req_kind_i  = 2'(kind);
    req_addr_i  = addr;
    while (!req_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int cyc = 0; cyc < 60 && !got; cyc++) begin
      if (cyc > 0) @(negedge clk_i);
      ack_i = '0;
      if (!snooped && (snp_inv_o != '0 || snp_fwd_o != '0)) begin
        snooped = 1;
        s_inv = snp_inv_o;
        s_fwd = snp_fwd_o;
        s_excl = snp_fwd_excl_o;
        pend = snp_inv_o | snp_fwd_o;
        gcnt = gap;
        check(snp_addr_o[15:6] == addr[15:6], rq, "snoop line", int'(snp_addr_o), int'(addr));
      end
      if (gnt_valid_o) begin
        got = 1;
        check(pend == '0, "R6", "acks outstanding at grant", int'(pend), 0);
        check(gnt_agent_o == 2'(ag), rq, "grant agent", int'(gnt_agent_o), ag);
        check(int'(gnt_state_o) == e_st, rq, "grant state", int'(gnt_state_o), e_st);
        check(gnt_from_cache_o == e_cache, rq, "from cache", int'(gnt_from_cache_o), int'(e_cache));
        check(mem_rd_o == e_rd, rq, "memory fill", int'(mem_rd_o), int'(e_rd));
        check(mem_wr_o == e_wr, rq, "memory write", int'(mem_wr_o), int'(e_wr));
        if (e_rd || e_wr)
          check(mem_addr_o[15:6] == addr[15:6], rq, "memory line", int'(mem_addr_o), int'(addr));
      end else begin
        if (req_ready_o) busy_bad = 1;
        if (pend != '0) begin
          if (gcnt == 0) begin
            for (int b = 0; b < 4; b++) begin
              if (pend[b]) begin
                ack_i[b] = 1'b1;
                pend[b] = 1'b0;
                break;
              end
            end
            gcnt = gap;
          end else begin
            gcnt--;
          end
        end
      end
    end
    ack_i = '0;
    check(got, rq, "grant seen", int'(got), 1);
    check(!busy_bad, "R6", "ready while busy", int'(busy_bad), 0);
    check(s_inv == e_inv, rq, "invalidate vector", int'(s_inv), int'(e_inv));
    check(s_fwd == e_fwd, rq, "forward vector", int'(s_fwd), int'(e_fwd));
    if (e_fwd != '0) check(s_excl == e_excl, rq, "forward exclusive", int'(s_excl), int'(e_excl));
    for (int b = 0; b < 4; b++) begin
      if (s_inv[b]) mdl[ln][b] = SI;
      if (s_fwd[b]) begin
        if (s_excl) mdl[ln][b] = SI;
        else if (mdl[ln][b] == SM || mdl[ln][b] == SE) mdl[ln][b] = SO;
      end
    end
    mdl[ln][ag] = (kind == KWB) ? SI : e_st;
    check_invariant(ln);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check(req_ready_o == 1'b1, "R1", "ready after reset", int'(req_ready_o), 1);
    check(!gnt_valid_o, "R1", "grant after reset", int'(gnt_valid_o), 0);
    check(snp_inv_o == '0 && snp_fwd_o == '0, "R1", "snoop after reset",
          int'(snp_inv_o | snp_fwd_o), 0);
    check(!mem_rd_o && !mem_wr_o, "R1", "memory strobe after reset",
          int'({mem_rd_o, mem_wr_o}), 0);
  endtask

  task automatic t_line_a;
    transact(0, KRS, 16'h1000, 4'b0000, 4'b0000, 0, SE, 0, 1, 0, 0, "R2");
    transact(1, KRS, 16'h1000, 4'b0000, 4'b0001, 0, SS, 1, 0, 0, 0, "R4");
    transact(2, KRS, 16'h1008, 4'b0000, 4'b0001, 0, SS, 1, 0, 0, 1, "R9");
    transact(0, KRO, 16'h1010, 4'b0110, 4'b0000, 0, SM, 0, 0, 0, 2, "R11");
    transact(3, KRO, 16'h1030, 4'b0000, 4'b0001, 1, SM, 1, 0, 0, 0, "R5");
    transact(2, KRS, 16'h1000, 4'b0000, 4'b1000, 0, SS, 1, 0, 0, 0, "R4");
    transact(3, KWB, 16'h1000, 4'b0000, 4'b0000, 0, SI, 0, 0, 1, 0, "R7");
    transact(2, KWB, 16'h1000, 4'b0000, 4'b0000, 0, SI, 0, 0, 0, 0, "R8");
    transact(1, KRS, 16'h1000, 4'b0000, 4'b0000, 0, SE, 0, 1, 0, 0, "R7");
  endtask

  task automatic t_line_b;
    transact(0, KRS, 16'h1040, 4'b0000, 4'b0000, 0, SE, 0, 1, 0, 0, "R2");
    transact(1, KRS, 16'h1040, 4'b0000, 4'b0001, 0, SS, 1, 0, 0, 0, "R4");
    transact(0, KWB, 16'h1040, 4'b0000, 4'b0000, 0, SI, 0, 0, 1, 0, "R7");
    transact(2, KRS, 16'h1040, 4'b0000, 4'b0000, 0, SS, 0, 1, 0, 0, "R3");
    transact(1, KWB, 16'h1040, 4'b0000, 4'b0000, 0, SI, 0, 0, 0, 0, "R8");
    transact(3, KRO, 16'h1040, 4'b0100, 4'b0000, 0, SM, 0, 1, 0, 0, "R5");
  endtask

  task automatic t_slow_acks;
    transact(0, KRS, 16'h2000, 4'b0000, 4'b0000, 0, SE, 0, 1, 0, 0, "R2");
    transact(1, KRS, 16'h2000, 4'b0000, 4'b0001, 0, SS, 1, 0, 0, 0, "R4");
    transact(2, KRS, 16'h2000, 4'b0000, 4'b0001, 0, SS, 1, 0, 0, 0, "R4");
    transact(3, KRO, 16'h2000, 4'b0110, 4'b0001, 1, SM, 1, 0, 0, 4, "R6");
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog run did not complete actual=1 expected=0");
    finish_run();
  end

  initial begin
    for (int l = 0; l < 3; l++)
      for (int a = 0; a < 4; a++) mdl[l][a] = SI;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_line_a();
    t_line_b();
    t_slow_acks();
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule